// File: doc/BRIEF.md
# Serial Flash Identification Responder

This block is the target-side logic that answers an identification read on a serial flash bus. It runs on a fast system clock and watches the serial clock and an active-low select as ordinary inputs. It finds the serial clock edges with a one-register edge detector. The bus works in one of three widths: one lane, two lanes or four lanes. In every width an 8-bit command is shifted in, most significant bit first, on the lanes of that width.

If the command is an identification code for the active width, the block streams its identification bytes back on the falling serial clock edges. In single-lane operation the reply goes out on a separate return lane. The reply is a manufacturer byte, then the device bytes, and in single-lane operation only, a block of unique-ID bytes after them. Any other command leaves every lane undriven for the rest of the frame.

The block has no tristate buffers of its own. It presents the data to drive and a per-lane enable, both registered, and the pad ring is expected to build the bidirectional lanes from them.

Top module: `spi_id_responder`

## Requirements
- R1: After reset, and in every system clock cycle that follows one in which `cs_n` was sampled high, `dq_oe` is 0. A new frame always starts its command count from zero.
- R2: The bus width is taken from `mode` only while `cs_n` is high. The encodings are 0 for one lane, 1 for two lanes, 2 for four lanes, and 3 for one lane again. A change of `mode` while selected has no effect on that frame.
- R3: In one-lane width the command is sampled from `dq_in[0]` on 8 rising serial clock edges, most significant bit first. No lane is enabled while it is being received.
- R4: In two-lane width the command is sampled on 4 rising edges, with `dq_in[1]` carrying the more significant bit of each pair. In four-lane width it is sampled on 2 rising edges, with `dq_in[3]` carrying the most significant bit of each nibble. No lane is enabled while the command is being received.
- R5: The codes 0x9E and 0x9F are accepted in one-lane width. Only 0xAF is accepted in two-lane and four-lane widths.
- R6: The reply is updated on each falling serial clock edge. It starts with the falling edge that ends the last command clock. It uses `dq_out[1]` alone in one-lane width, `dq_out[1:0]` in two-lane width (bit 1 more significant), and `dq_out[3:0]` in four-lane width (bit 3 most significant). Each byte is sent most significant bit first.
- R7: The reply bytes are 0x20, then 0xBA, then 0x19. In one-lane width 17 unique-ID bytes follow, where byte k has the value 0x10+k.
- R8: On the first falling edge after the last reply bit, all lanes are released. They stay released until the frame ends.
- R9: After an unaccepted command, no lane is enabled until `cs_n` goes high.
- R10: Raising `cs_n` in the middle of a reply releases all lanes. The next frame starts its reply again from the manufacturer byte.
- R11: While selected, `dq_out` and `dq_oe` change only in response to a falling serial clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock, already synchronous to `clk`, idle low |
| cs_n | input | 1 | Active-low select |
| mode | input | 2 | Bus width select (0/3 one lane, 1 two lanes, 2 four lanes) |
| dq_in | input | 4 | Sampled values of the data lanes |
| dq_out | output | 4 | Values to drive on the data lanes |
| dq_oe | output | 4 | Per-lane output enable |

## Verification
A command counter that drifts by one beat shows up straight away. The reply either opens one serial clock early, while the command lanes are still being driven, or it shifts every returned bit by one lane position, so the very first reply sample is wrong. A wrong byte index or bit pointer corrupts the next nibble, pair or bit on the outputs. A wrong stop point leaves the enable high for one extra serial clock. A latched bus width or a decode flag left over from a previous frame appears in the first reply sample of the next frame as the wrong lanes or an enable that never rises.

// File: rtl/spi_id_pkg.sv
package spi_id_pkg;

  typedef enum logic [1:0] {
    BUS_X1  = 2'd0,
    BUS_X2  = 2'd1,
    BUS_X4  = 2'd2,
    BUS_X1B = 2'd3
  } bus_mode_e;

  function automatic logic [2:0] lane_count(input bus_mode_e m);
    case (m)
      BUS_X2:  return 3'd2;
      BUS_X4:  return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input bus_mode_e m);
    case (m)
      BUS_X2:  return 4'b0011;
      BUS_X4:  return 4'b1111;
      default: return 4'b0010;
    endcase
  endfunction

  function automatic logic is_single(input bus_mode_e m);
    return (m == BUS_X1) || (m == BUS_X1B);
  endfunction

endpackage

// File: rtl/spi_id_edge.sv
module spi_id_edge (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  output logic rise,
  output logic fall
);
  logic sck_q;

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck;
  end

  assign rise = sck & ~sck_q;
  assign fall = ~sck & sck_q;
endmodule

// File: rtl/spi_id_cmd.sv
module spi_id_cmd
  import spi_id_pkg::*;
#(
  parameter int          CMD_W    = 8,
  parameter logic [7:0]  CODE_X1A = 8'h9E,
  parameter logic [7:0]  CODE_X1B = 8'h9F,
  parameter logic [7:0]  CODE_MIO = 8'hAF
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sel,
  input  logic      rise,
  input  bus_mode_e mode,
  input  logic [3:0] dq_in,
  output logic      cmd_done,
  output logic      cmd_hit
);
  localparam int CNT_W = $clog2(CMD_W + 1);
  localparam logic [CNT_W-1:0] BEATS_X1 = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] BEATS_X2 = CNT_W'(CMD_W / 2);
  localparam logic [CNT_W-1:0] BEATS_X4 = CNT_W'(CMD_W / 4);

  logic [CMD_W-1:0] sr_q, sr_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx, beats;
  logic             hit_nx;

  always_comb begin
    case (mode)
      BUS_X2: begin
        sr_nx = {sr_q[CMD_W-3:0], dq_in[1:0]};
        beats = BEATS_X2;
      end
      BUS_X4: begin
        sr_nx = {sr_q[CMD_W-5:0], dq_in[3:0]};
        beats = BEATS_X4;
      end
      default: begin
        sr_nx = {sr_q[CMD_W-2:0], dq_in[0]};
        beats = BEATS_X1;
      end
    endcase
    cnt_nx = cnt_q + CNT_W'(1);
    if (is_single(mode)) hit_nx = (sr_nx == CODE_X1A) || (sr_nx == CODE_X1B);
    else                 hit_nx = (sr_nx == CODE_MIO);
  end

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      sr_q     <= '0;
      cnt_q    <= '0;
      cmd_done <= 1'b0;
      cmd_hit  <= 1'b0;
    end else if (rise && !cmd_done) begin
      sr_q  <= sr_nx;
      cnt_q <= cnt_nx;
      if (cnt_nx == beats) begin
        cmd_done <= 1'b1;
        cmd_hit  <= hit_nx;
      end
    end
  end

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= BEATS_X1);                                        // R4
  AST_DECODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && sel) |=> (cmd_done && $stable(cmd_hit)));     // R9
endmodule

// File: rtl/spi_id_reply.sv
module spi_id_reply
  import spi_id_pkg::*;
#(
  parameter int                      DEV_BYTES = 2,
  parameter int                      UID_BYTES = 17,
  parameter logic [7:0]              MFR_ID    = 8'h20,
  parameter logic [8*DEV_BYTES-1:0]  DEV_ID    = 16'hBA19,
  parameter logic [8*UID_BYTES-1:0]  UID_DATA  = 136'h101112131415161718191A1B1C1D1E1F20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic       fall,
  input  logic       go,
  input  bus_mode_e  mode,
  output logic [3:0] dq_out,
  output logic [3:0] dq_oe
);
  localparam int LEN_X1  = 1 + DEV_BYTES + UID_BYTES;
  localparam int LEN_MIO = 1 + DEV_BYTES;
  localparam int IDX_W   = $clog2(LEN_X1 + 1);
  localparam int ALL_W   = 8 * LEN_X1;
  localparam logic [ALL_W-1:0] ID_ALL = {MFR_ID, DEV_ID, UID_DATA};

  logic [IDX_W-1:0] idx_q, len;
  logic [2:0]       bit_q, step;
  logic [3:0]       bit_nx, lanes_nx;
  logic             fin_q;
  logic [ALL_W-1:0] id_sh;
  logic [7:0]       cur_byte, byte_sh;

  always_comb begin
    len      = is_single(mode) ? IDX_W'(LEN_X1) : IDX_W'(LEN_MIO);
    step     = lane_count(mode);
    id_sh    = ID_ALL << {idx_q, 3'b000};
    cur_byte = id_sh[ALL_W-1 -: 8];
    byte_sh  = cur_byte << bit_q;
    bit_nx   = {1'b0, bit_q} + {1'b0, step};
    case (mode)
      BUS_X2:  lanes_nx = {2'b00, byte_sh[7:6]};
      BUS_X4:  lanes_nx = byte_sh[7:4];
      default: lanes_nx = {2'b00, byte_sh[7], 1'b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      idx_q  <= '0;
      bit_q  <= '0;
      fin_q  <= 1'b0;
      dq_out <= '0;
      dq_oe  <= '0;
    end else if (fall && go && !fin_q) begin
      if (idx_q < len) begin
        dq_out <= lanes_nx;
        dq_oe  <= lane_mask(mode);
        if (bit_nx == 4'd8) begin
          bit_q <= '0;
          idx_q <= idx_q + IDX_W'(1);
        end else begin
          bit_q <= bit_nx[2:0];
        end
      end else begin
        dq_out <= '0;
        dq_oe  <= '0;
        fin_q  <= 1'b1;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sel && !fall) |=> ($stable(dq_out) && $stable(dq_oe)));   // R11
  AST_LANES_X1: assert property (@(posedge clk) disable iff (rst)
    is_single(mode) |-> (dq_oe == 4'b0000 || dq_oe == 4'b0010)); // R6
  AST_LANES_X2: assert property (@(posedge clk) disable iff (rst)
    (mode == BUS_X2) |-> (dq_oe == 4'b0000 || dq_oe == 4'b0011)); // R6
  AST_LANES_X4: assert property (@(posedge clk) disable iff (rst)
    (mode == BUS_X4) |-> (dq_oe == 4'b0000 || dq_oe == 4'b1111)); // R6
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    idx_q <= len);                                             // R8
endmodule

// File: rtl/spi_id_responder.sv
module spi_id_responder
  import spi_id_pkg::*;
#(
  parameter int                      DEV_BYTES = 2,
  parameter int                      UID_BYTES = 17,
  parameter logic [7:0]              MFR_ID    = 8'h20,
  parameter logic [8*DEV_BYTES-1:0]  DEV_ID    = 16'hBA19,
  parameter logic [8*UID_BYTES-1:0]  UID_DATA  = 136'h101112131415161718191A1B1C1D1E1F20,
  parameter logic [7:0]              CODE_X1A  = 8'h9E,
  parameter logic [7:0]              CODE_X1B  = 8'h9F,
  parameter logic [7:0]              CODE_MIO  = 8'hAF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck,
  input  logic       cs_n,
  input  logic [1:0] mode,
  input  logic [3:0] dq_in,
  output logic [3:0] dq_out,
  output logic [3:0] dq_oe
);
  bus_mode_e mode_q;
  logic      sel, rise, fall, cmd_done, cmd_hit;

  assign sel = ~cs_n;

  always_ff @(posedge clk) begin
    if (rst)       mode_q <= BUS_X1;
    else if (cs_n) mode_q <= bus_mode_e'(mode);
  end

  spi_id_edge edge_i (
    .clk (clk),
    .rst (rst),
    .sck (sck),
    .rise(rise),
    .fall(fall)
  );

  spi_id_cmd #(
    .CMD_W   (8),
    .CODE_X1A(CODE_X1A),
    .CODE_X1B(CODE_X1B),
    .CODE_MIO(CODE_MIO)
  ) cmd_i (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .rise    (rise),
    .mode    (mode_q),
    .dq_in   (dq_in),
    .cmd_done(cmd_done),
    .cmd_hit (cmd_hit)
  );

  spi_id_reply #(
    .DEV_BYTES(DEV_BYTES),
    .UID_BYTES(UID_BYTES),
    .MFR_ID   (MFR_ID),
    .DEV_ID   (DEV_ID),
    .UID_DATA (UID_DATA)
  ) reply_i (
    .clk   (clk),
    .rst   (rst),
    .sel   (sel),
    .fall  (fall),
    .go    (cmd_done & cmd_hit),
    .mode  (mode_q),
    .dq_out(dq_out),
    .dq_oe (dq_oe)
  );

  AST_DESEL_RELEASE: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (dq_oe == 4'b0000));                              // R1
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cs_n |=> $stable(mode_q));                                // R2
  AST_CMD_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cmd_done |-> (dq_oe == 4'b0000));                         // R3
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && !cmd_hit) |-> (dq_oe == 4'b0000));            // R9
endmodule

// File: tb/spi_id_responder_tb.sv
module spi_id_responder_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sck = 1'b0;
  logic       cs_n = 1'b1;
  logic [1:0] mode = 2'd0;
  logic [3:0] dq_in = 4'd0;
  logic [3:0] dq_out, dq_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  string ctx  = "";

  logic [3:0] post_out [0:255];
  logic [3:0] post_oe  [0:255];
  logic [3:0] pre_out  [0:255];
  logic [3:0] pre_oe   [0:255];

  always #10 clk = ~clk;

  spi_id_responder dut_i (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mode(mode),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic int width_of(input int m);
    return (m == 1) ? 2 : (m == 2) ? 4 : 1;
  endfunction

  function automatic logic [3:0] mask_of(input int m);
    return (m == 1) ? 4'b0011 : (m == 2) ? 4'b1111 : 4'b0010;
  endfunction

  function automatic bit accepted(input int m, input logic [7:0] c);
    if (m == 0 || m == 3) return (c == 8'h9E) || (c == 8'h9F);
    return c == 8'hAF;
  endfunction

  function automatic int reply_len(input int m);
    return (m == 0 || m == 3) ? 20 : 3;
  endfunction

  function automatic logic [7:0] id_byte(input int k);
    if (k == 0) return 8'h20;
    if (k == 1) return 8'hBA;
    if (k == 2) return 8'h19;
    return 8'(8'h10 + k - 3);
  endfunction

  function automatic logic stream_bit(input int n);
    logic [7:0] b;
    b = id_byte(n / 8);
    return b[7 - (n % 8)];
  endfunction

  function automatic logic [3:0] exp_lanes(input int m, input int j);
    logic [3:0] v;
    int w;
    v = 4'd0;
    w = width_of(m);
    if (w == 1) v[1] = stream_bit(j);
    else if (w == 2) begin
      v[1] = stream_bit(2 * j);
      v[0] = stream_bit(2 * j + 1);
    end else begin
      for (int l = 0; l < 4; l++) v[3 - l] = stream_bit(4 * j + l);
    end
    return v;
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, ctx, act, exp);
    end
  endtask

  task automatic sck_pulse(input int i);
    @(negedge clk); sck = 1'b1;
    @(negedge clk);
    @(negedge clk);
    pre_out[i] = dq_out; pre_oe[i] = dq_oe;
    @(negedge clk); sck = 1'b0;
    @(negedge clk);
    @(negedge clk);
    post_out[i] = dq_out; post_oe[i] = dq_oe;
  endtask

  task automatic run_frame(input int m, input logic [7:0] cmd, input int nclk,
                           input int chg_at, input int chg_mode);
    int w, beats;
    logic [7:0] c;
    w = width_of(m);
    beats = 8 / w;
    @(negedge clk); cs_n = 1'b1; mode = 2'(m);
    @(negedge clk);
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      if (i == chg_at) mode = 2'(chg_mode);
      if (i < beats) begin
        c = cmd << (i * w);
        dq_in = (w == 1) ? {3'b000, c[7]} : (w == 2) ? {2'b00, c[7:6]} : c[7:4];
      end else dq_in = 4'd0;
      sck_pulse(i);
    end
    @(negedge clk); cs_n = 1'b1; dq_in = 4'd0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_frame(input int m, input logic [7:0] cmd, input int nclk);
    int w, beats, nb, j;
    bit hit;
    logic [3:0] eoe;
    w = width_of(m);
    beats = 8 / w;
    hit = accepted(m, cmd);
    nb = reply_len(m) * 8 / w;
    for (int i = 0; i < nclk; i++) begin
      if (i < beats - 1) begin
        check((w == 1) ? "R3" : "R4", post_oe[i], 4'd0);
      end else begin
        j = i - (beats - 1);
        if (hit && j < nb) begin
          eoe = mask_of(m);
          check((j == 0) ? "R5" : "R6", post_oe[i], eoe);
          check("R7", post_out[i], exp_lanes(m, j));
        end else begin
          check(hit ? "R8" : "R9", post_oe[i], 4'd0);
        end
      end
      if (i > 0) begin
        check("R11", pre_oe[i], post_oe[i-1]);
        check("R11", pre_out[i], post_out[i-1]);
      end
    end
  endtask

  task automatic full_frame(input int m, input logic [7:0] cmd, input int chg_at, input int chg_mode);
    int nclk;
    nclk = accepted(m, cmd) ? (8 / width_of(m)) - 1 + reply_len(m) * 8 / width_of(m) + 2
                            : (8 / width_of(m)) + 3;
    run_frame(m, cmd, nclk, chg_at, chg_mode);
    check_frame(m, cmd, nclk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    ctx = "after reset";
    check("R1", dq_oe, 4'd0);

    // R2: mode changes while selected are ignored; encoding 3 acts as one lane
    ctx = "R2 mode switched mid-frame";
    full_frame(0, 8'h9F, 3, 2);
    ctx = "R2 mode switched mid-frame quad";
    full_frame(2, 8'hAF, 1, 0);

    // R10: abort in the middle of a reply, then restart
    ctx = "R10 abort";
    run_frame(2, 8'hAF, 3, -1, 0);
    check("R10", dq_oe, 4'd0);
    ctx = "R10 restart after abort";
    full_frame(2, 8'hAF, -1, 0);
    ctx = "R10 abort one lane";
    run_frame(0, 8'h9E, 20, -1, 0);
    check("R10", dq_oe, 4'd0);
    ctx = "R10 restart one lane";
    full_frame(0, 8'h9E, -1, 0);

    // Exhaustive sweep over every command code in every mode encoding
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 256; c++) begin
        $sformat(ctx, "mode %0d cmd %02h", m, c);
        full_frame(m, 8'(c), -1, 0);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule